// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. A counter sets the pulse length, so no RC network is needed. It watches two trigger inputs of opposite edge polarity. A rising edge on `trig_rise` counts as a trigger only while `trig_fall` is high. A falling edge on `trig_fall` counts as a trigger only while `trig_rise` is low. An accepted trigger drives the complementary pair `q` / `q_n` for a programmable number of clock cycles. The trigger's own duration does not affect that length.

Each accepted trigger is followed by a short discharge window, and triggers that arrive during it are dropped. This sets a minimum retrigger interval. The `retrig_en` input selects between two modes:
- With `retrig_en` high, a later valid trigger restarts the full count, which stretches the pulse.
- With `retrig_en` low, triggers that arrive while the pulse is active are ignored.

An active-low clear (`clr_n`) ends any pulse at once and blocks triggers. After the system reset `rst_n` is released, a power-on lockout blocks triggers for a fixed number of cycles.

Top module: `mono_oneshot`

## Requirements
- R1: A rising edge on `trig_rise` starts a pulse when `trig_fall` is high. A rising edge on `trig_rise` while `trig_fall` is low starts nothing.
- R2: A falling edge on `trig_fall` starts a pulse when `trig_rise` is low. A falling edge on `trig_fall` while `trig_rise` is high starts nothing.
- R3: `q` goes high on the third rising clock edge after a qualifying input change, which is two synchronizer stages plus one accept register. It stays high for exactly `width_cycles` cycles. `width_cycles` is sampled when the trigger is accepted, so later changes to it and the trigger's duration have no effect.
- R4: A `width_cycles` value of 0 gives a pulse of one cycle.
- R5: While `clr_n` is low, `q` is low and `q_n` is high, with no clock edge needed. Triggers seen during that time are not accepted.
- R6: Pulling `clr_n` low during a pulse ends the pulse, and the pulse does not resume when `clr_n` is released. Once the release has crossed the synchronizer, the block accepts a new trigger normally.
- R7: For `POR_CYCLES` cycles (default 8) after `rst_n` is released, no trigger is accepted and `q` stays low. The trigger is dropped, not deferred.
- R8: With `retrig_en` = 1, a valid trigger during an active pulse reloads the full width from that trigger's accept edge. The pulse is then (accept distance + width) cycles long.
- R9: With `retrig_en` = 0, triggers that arrive while `q` is high are ignored. The pulse ends exactly `width_cycles` cycles after the first accept.
- R10: For `DISCHARGE_CYCLES` cycles (default 2) after each accept, further triggers are dropped. A trigger detected on the following cycle, three accept edges later with the default, is accepted.
- R11: `q_n` is always the complement of `q`, and both hold the idle state (`q` = 0) during `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; starts the power-on lockout on release |
| clr_n | input | 1 | Active-low functional clear; forces the outputs idle and cancels timing |
| trig_rise | input | 1 | Rising-edge trigger input, qualified by `trig_fall` high |
| trig_fall | input | 1 | Falling-edge trigger input, qualified by `trig_rise` low |
| retrig_en | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| width_cycles | input | 16 | Pulse length in clock cycles, sampled at accept; 0 acts as 1 |
| q | output | 1 | Pulse output, normally low |
| q_n | output | 1 | Complement of `q` |

## Verification
A table drives each trigger input with its qualifier level both valid and invalid, across widths of 0, 1 and several larger values. Each run reports the latency to the rising edge of `q` and the high length. Together these separate correct edge polarity, correct qualification, correct latency and correct length. Directed sequences put a second trigger two or three accept edges after the first, which isolates the edge of the discharge window. A second trigger ten cycles in, run in both modes, tells reload apart from ignore. Further directed tests change `width_cycles` in the middle of a pulse, pull `clr_n` low in the middle of a pulse, and fire a trigger during the power-on lockout. These show that the width is latched at accept, that the clear is immediate and does not resume the pulse, and that a trigger during the lockout is dropped, not deferred.

// File: rtl/mono_pkg.sv
package mono_pkg;

  localparam int unsigned WIDTH_BITS = 16;

  typedef logic [WIDTH_BITS-1:0] width_t;

  // Effective pulse length: a request of zero still yields one cycle.
  function automatic width_t eff_width(input width_t req);
    return (req == '0) ? width_t'(1) : req;
  endfunction

  // Remaining-count step while a pulse runs.
  function automatic width_t count_step(input width_t cur);
    return (cur == '0) ? '0 : width_t'(cur - width_t'(1));
  endfunction

endpackage

// File: rtl/mono_sync.sv
module mono_sync #(
  parameter int unsigned BITS    = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [BITS-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);

  for (genvar g = 0; g < BITS; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/mono_trig_qual.sv
module mono_trig_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic fall_s,
  output logic trig_evt
);

  logic rise_d, fall_d;
  logic rise_hit, fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      rise_d <= rise_s;
      fall_d <= fall_s;
    end
  end

  // R1: positive edge on the rising input, qualified by the other input high
  assign rise_hit = rise_s & ~rise_d & fall_s;
  // R2: negative edge on the falling input, qualified by the other input low
  assign fall_hit = ~fall_s & fall_d & ~rise_s;
  assign trig_evt = rise_hit | fall_hit;

  // R1
  qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_hit) |-> (fall_s && !fall_hit));

  // R2
  qual_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_hit) |-> (!rise_s && !rise_hit));

endmodule

// File: rtl/mono_por.sv
module mono_por #(
  parameter int unsigned POR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_done
);

  localparam int unsigned PW = $clog2(POR_CYCLES + 1);
  localparam logic [PW-1:0] LAST = PW'(POR_CYCLES);

  logic [PW-1:0] por_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                por_cnt <= '0;
    else if (por_cnt != LAST)  por_cnt <= por_cnt + 1'b1;
  end

  assign por_done = (por_cnt == LAST);

  // R7
  por_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_done |=> por_done);

endmodule

// File: rtl/mono_timer.sv
module mono_timer
  import mono_pkg::*;
#(
  parameter int unsigned DISCHARGE_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_s,
  input  logic   por_done,
  input  logic   trig_evt,
  input  logic   retrig_en,
  input  width_t width_req,
  output logic   active,
  output logic   accept
);

  localparam int unsigned LW = (DISCHARGE_CYCLES < 1) ? 1 : $clog2(DISCHARGE_CYCLES + 1);
  localparam logic [LW-1:0] LOCK_LOAD = LW'(DISCHARGE_CYCLES);

  width_t        remain;
  logic [LW-1:0] lock_cnt;
  logic          locked;
  width_t        load_w;

  assign locked = (lock_cnt != '0);
  assign active = (remain != '0);
  assign load_w = eff_width(width_req);

  // R5 R7 R9 R10: every gate on acceptance
  assign accept = trig_evt & por_done & clr_s & ~locked & (retrig_en | ~active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain   <= '0;
      lock_cnt <= '0;
    end else if (!clr_s) begin
      remain   <= '0;
      lock_cnt <= '0;
    end else if (accept) begin
      remain   <= load_w;
      lock_cnt <= LOCK_LOAD;
    end else begin
      remain   <= count_step(remain);
      if (locked) lock_cnt <= lock_cnt - 1'b1;
    end
  end

  // R3
  load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (remain == $past(load_w)));

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !accept && clr_s) |=> (remain == $past(remain) - 1'b1));

  // R9
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && active && clr_s) |=> (remain == $past(remain) - 1'b1));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && remain > 1 && clr_s) |=> (remain == $past(remain) - 1'b1));

  // R7
  por_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> !active);

  // R5
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (!active && !locked));

endmodule

// File: rtl/mono_oneshot.sv
module mono_oneshot
  import mono_pkg::*;
#(
  parameter int unsigned POR_CYCLES       = 8,
  parameter int unsigned DISCHARGE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  trig_rise,
  input  logic                  trig_fall,
  input  logic                  retrig_en,
  input  logic [WIDTH_BITS-1:0] width_cycles,
  output logic                  q,
  output logic                  q_n
);

  logic [2:0] raw_in, sync_out;
  logic       rise_s, fall_s, clr_s;
  logic       trig_evt, por_done, active, accept;

  assign raw_in = {clr_n, trig_fall, trig_rise};

  mono_sync #(
    .BITS    (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (sync_out)
  );

  assign rise_s = sync_out[0];
  assign fall_s = sync_out[1];
  assign clr_s  = sync_out[2];

  mono_trig_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_s   (rise_s),
    .fall_s   (fall_s),
    .trig_evt (trig_evt)
  );

  mono_por #(
    .POR_CYCLES (POR_CYCLES)
  ) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_done (por_done)
  );

  mono_timer #(
    .DISCHARGE_CYCLES (DISCHARGE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_s     (clr_s),
    .por_done  (por_done),
    .trig_evt  (trig_evt),
    .retrig_en (retrig_en),
    .width_req (width_cycles),
    .active    (active),
    .accept    (accept)
  );

  // R5: the raw clear gates the output so it acts before synchronization
  assign q   = active & clr_n;
  assign q_n = ~q;

  // R11
  comp_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == !q);

  // R5
  clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (!q && q_n));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr_n) |=> q || !clr_n);

endmodule

// File: tb/tb_mono_oneshot.sv
module tb_mono_oneshot;

  logic        clk = 1'b0;
  logic        rst_n, clr_n, trig_rise, trig_fall, retrig_en;
  logic [15:0] width_cycles;
  logic        q, q_n;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #2 clk = ~clk;

  mono_oneshot dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_n        (clr_n),
    .trig_rise    (trig_rise),
    .trig_fall    (trig_fall),
    .retrig_en    (retrig_en),
    .width_cycles (width_cycles),
    .q            (q),
    .q_n          (q_n)
  );

  // kind: 0 rise w/ fall-in high, 1 fall w/ rise-in low,
  //       2 rise w/ fall-in low (no fire), 3 fall w/ rise-in high (no fire)
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 16'd5}, {2'd1, 16'd5}, {2'd0, 16'd1}, {2'd1, 16'd17},
    {2'd2, 16'd5}, {2'd3, 16'd5}, {2'd0, 16'd0}, {2'd1, 16'd33}
  };

  function automatic int exp_len(input int kind, input int w);
    if (kind >= 2) return 0;
    return (w < 1) ? 1 : w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts negedges until q rises (lat) and the number of high samples (len).
  task automatic measure(input int limit, output int lat, output int len, output int comp_bad);
    lat = 0; len = 0; comp_bad = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk); #1;
      if (q_n !== ~q) comp_bad++;
      if (q === 1'b1) begin
        if (lat == 0) lat = i;
        len++;
      end else if (lat != 0) begin
        break;
      end
    end
  endtask

  task automatic go_idle_levels();
    @(negedge clk); trig_rise = 1'b0;
    idle(2);        trig_fall = 1'b1;
    idle(60);
  endtask

  int lat, len, cb;

  initial begin : main
    rst_n = 1'b0; clr_n = 1'b1; trig_rise = 1'b0; trig_fall = 1'b1;
    retrig_en = 1'b1; width_cycles = 16'd6;
    idle(3); #1;
    // R11 reset state
    chk("R11 reset q", int'(q), 0);
    chk("R11 reset q_n", int'(q_n), 1);

    // R7: trigger right at release of reset is dropped
    @(negedge clk); rst_n = 1'b1; trig_rise = 1'b1;
    measure(40, lat, len, cb);
    chk("R7 por lockout len", len, 0);
    go_idle_levels();

    // Table of trigger patterns
    for (int v = 0; v < 8; v++) begin
      int kind, w;
      kind = int'(VEC[v][17:16]);
      w    = int'(VEC[v][15:0]);
      width_cycles = VEC[v][15:0];
      if (kind == 2) begin
        @(negedge clk); trig_rise = 1'b1; idle(60);
        trig_fall = 1'b0; idle(2); trig_rise = 1'b0; idle(60);
      end else if (kind == 3) begin
        @(negedge clk); trig_rise = 1'b1; idle(60);
      end
      @(negedge clk);
      if (kind == 0 || kind == 2) trig_rise = 1'b1;
      else                        trig_fall = 1'b0;
      measure(80, lat, len, cb);
      if (kind == 0)      chk("R1 rise fires len", len, exp_len(kind, w));
      else if (kind == 1) chk("R2 fall fires len", len, exp_len(kind, w));
      else if (kind == 2) chk("R1 rise unqualified len", len, 0);
      else                chk("R2 fall unqualified len", len, 0);
      if (kind < 2) chk("R3 latency", lat, 3);
      if (w == 0 && kind < 2) chk("R4 zero width", len, 1);
      chk("R11 complement", cb, 0);
      go_idle_levels();
    end

    // R3: width sampled at accept; later change has no effect
    width_cycles = 16'd10;
    @(negedge clk); trig_rise = 1'b1;
    fork
      measure(60, lat, len, cb);
      begin idle(4); width_cycles = 16'd2; end
    join
    chk("R3 width latched", len, 10);
    go_idle_levels();

    // R8: retrigger 10 cycles later stretches
    retrig_en = 1'b1; width_cycles = 16'd20;
    @(negedge clk); trig_rise = 1'b1;
    fork
      measure(80, lat, len, cb);
      begin idle(5); trig_rise = 1'b0; idle(5); trig_rise = 1'b1; end
    join
    chk("R8 retrigger stretch", len, 30);
    go_idle_levels();

    // R9: same stimulus in non-retriggerable mode
    retrig_en = 1'b0;
    @(negedge clk); trig_rise = 1'b1;
    fork
      measure(80, lat, len, cb);
      begin idle(5); trig_rise = 1'b0; idle(5); trig_rise = 1'b1; end
    join
    chk("R9 no retrigger", len, 20);
    go_idle_levels();
    retrig_en = 1'b1;

    // R10: second edge two accept edges later is dropped
    width_cycles = 16'd10;
    @(negedge clk); trig_rise = 1'b1;
    fork
      measure(60, lat, len, cb);
      begin idle(1); trig_rise = 1'b0; idle(1); trig_rise = 1'b1; end
    join
    chk("R10 lockout drops", len, 10);
    go_idle_levels();

    // R10: three accept edges later is accepted
    @(negedge clk); trig_rise = 1'b1;
    fork
      measure(60, lat, len, cb);
      begin idle(1); trig_rise = 1'b0; idle(2); trig_rise = 1'b1; end
    join
    chk("R10 lockout ends", len, 13);
    go_idle_levels();

    // R5/R6: clear during a pulse
    width_cycles = 16'd40;
    @(negedge clk); trig_rise = 1'b1;
    idle(8);
    clr_n = 1'b0; #1;
    chk("R6 clear ends pulse q", int'(q), 0);
    chk("R5 clear q_n high", int'(q_n), 1);
    trig_rise = 1'b0; idle(4); trig_rise = 1'b1;
    measure(20, lat, len, cb);
    chk("R5 trigger under clear", len, 0);
    clr_n = 1'b1;
    measure(50, lat, len, cb);
    chk("R6 no resume after clear", len, 0);
    go_idle_levels();
    width_cycles = 16'd7;
    @(negedge clk); trig_fall = 1'b0;
    measure(40, lat, len, cb);
    chk("R6 ready after clear", len, 7);
    chk("R6 latency after clear", lat, 3);
    go_idle_levels();

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule